// File: doc/BRIEF.md
# Parallel Printer Port Transmitter

This block drives the host end of a byte-wide parallel printer link. A byte offered on a valid/ready handshake is registered onto the data pins. After a fixed setup interval an active-low strobe pulse of fixed length follows. The block then watches the printer's active-low acknowledge line. A transfer completes only when acknowledge goes low and then returns high after the strobe has finished. Two sticky flags report the outcome for a polling CPU: one for success, one for a timeout.

The acknowledge and busy inputs each cross into the clock domain through a synchronizer chain. Edge detection then runs on the synchronized acknowledge. An acknowledge that appears while the setup or strobe timer is running is discarded. This covers a printer that answers too early, and a stale acknowledge left over from an earlier exchange. The setup length, strobe length and acknowledge timeout are all counted in clock cycles and set by parameters.

The controller has five states:
- `ST_IDLE`: waits for a byte.
- `ST_SETUP`: data is stable and the strobe is still high.
- `ST_STROBE`: strobe low.
- `ST_WAIT_FALL`: waits for acknowledge to go low.
- `ST_WAIT_RISE`: waits for acknowledge to return high.

Transitions:
- IDLE→SETUP on accept.
- SETUP→STROBE when the setup count ends.
- STROBE→WAIT_FALL when the strobe count ends.
- WAIT_FALL→WAIT_RISE on a synchronized acknowledge fall.
- WAIT_RISE→IDLE on a synchronized acknowledge rise, which sets the success flag.
- WAIT_FALL→IDLE or WAIT_RISE→IDLE when the timeout count ends, which sets the timeout flag.

Top module: `pport_tx`

## Requirements
- R1: After reset, `strobe_n` is 1, `done` and `timeout_err` are 0, `pd_out` is 0, and `tx_ready` is 1 while `busy_in` is low.
- R2: A byte is accepted only on a clock edge where `tx_valid` and `tx_ready` are both 1. `tx_ready` is 0 while a transfer is in progress, and 0 while the synchronized `busy_in` is high. A held `tx_valid` is accepted once busy falls.
- R3: The accepted byte appears on `pd_out` one cycle after the accepting edge. It stays unchanged until the next accept.
- R4: `strobe_n` goes low exactly SETUP_CYCLES clock cycles after the accepting edge.
- R5: `strobe_n` stays low for exactly STB_CYCLES cycles.
- R6: An acknowledge fall or rise whose synchronized edge occurs before the strobe has ended has no effect. In particular, it does not set `done`.
- R7: After the strobe ends, `ack_n_in` going low and then high sets `done` to 1. `done` rises on the third clock edge after `ack_n_in` returns high (two synchronizer stages plus the state change), and the block returns to idle.
- R8: An acknowledge that went low during the strobe and returns high after it does not complete the transfer.
- R9: If no completing acknowledge arrives, `timeout_err` becomes 1 exactly TIMEOUT_CYCLES cycles after `strobe_n` returns high. In that case `done` stays 0 and `tx_ready` returns to 1.
- R10: `done` and `timeout_err` are never 1 together, and both clear on the edge that accepts the next byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_data | input | DATA_W | Byte to send |
| tx_valid | input | 1 | Byte offered |
| tx_ready | output | 1 | Block can take a byte |
| pd_out | output | DATA_W | Data lines to printer |
| strobe_n | output | 1 | Active-low data strobe |
| ack_n_in | input | 1 | Active-low acknowledge from printer (asynchronous) |
| busy_in | input | 1 | Printer busy (asynchronous) |
| done | output | 1 | Sticky: last transfer acknowledged |
| timeout_err | output | 1 | Sticky: last transfer timed out |

## Verification
The bench builds the block with SETUP_CYCLES=3, STB_CYCLES=20 and TIMEOUT_CYCLES=400. These keep every interval short enough to measure exactly to the cycle. The strobe is still long enough that a complete acknowledge pulse can pass through the synchronizers while the strobe is low, which makes the early-acknowledge case reachable. The short timeout lets the bench reach both the plain timeout and the timeout caused by an acknowledge that straddles the end of the strobe, at the exact expected cycle.

// File: rtl/pport_pkg.sv
package pport_pkg;

    typedef enum logic [2:0] {
        ST_IDLE      = 3'd0,
        ST_SETUP     = 3'd1,
        ST_STROBE    = 3'd2,
        ST_WAIT_FALL = 3'd3,
        ST_WAIT_RISE = 3'd4
    } pport_state_e;

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/pport_sync.sv
module pport_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);
    logic [STAGES-1:0] chain;

    generate
        genvar i;
        for (i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[0] <= RST_VAL;
                    else        chain[0] <= async_in;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[i] <= RST_VAL;
                    else        chain[i] <= chain[i-1];
                end
            end
        end
    endgenerate

    assign sync_out = chain[STAGES-1];
endmodule

// File: rtl/pport_timer.sv
module pport_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          cnt <= '0;
        else if (load)       cnt <= load_val;
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == '0);
endmodule

// File: rtl/pport_datareg.sv
module pport_datareg #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       dout <= '0;
        else if (capture) dout <= din;
    end
endmodule

// File: rtl/pport_tx.sv
module pport_tx
    import pport_pkg::*;
#(
    parameter int DATA_W         = 8,
    parameter int SETUP_CYCLES   = 5,
    parameter int STB_CYCLES     = 50,
    parameter int TIMEOUT_CYCLES = 5000,
    parameter int SYNC_STAGES    = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              tx_valid,
    output logic              tx_ready,
    output logic [DATA_W-1:0] pd_out,
    output logic              strobe_n,
    input  logic              ack_n_in,
    input  logic              busy_in,
    output logic              done,
    output logic              timeout_err
);
    localparam int MAX_CNT = max3(SETUP_CYCLES, STB_CYCLES, TIMEOUT_CYCLES);
    localparam int CNT_W   = $clog2(MAX_CNT + 1);
    localparam logic [CNT_W-1:0] SETUP_LD = CNT_W'(SETUP_CYCLES - 1);
    localparam logic [CNT_W-1:0] STB_LD   = CNT_W'(STB_CYCLES - 1);
    localparam logic [CNT_W-1:0] TO_LD    = CNT_W'(TIMEOUT_CYCLES - 1);

    pport_state_e state, state_nx;

    logic ack_s, ack_prev, busy_s;
    logic ack_fall, ack_rise;
    logic accept;
    logic tmr_load, tmr_exp;
    logic [CNT_W-1:0] tmr_val;
    logic finish_ok, finish_to;

    // Input synchronizers: acknowledge idles high, busy idles low
    pport_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_ack_sync (
        .clk(clk), .rst_n(rst_n), .async_in(ack_n_in), .sync_out(ack_s)
    );
    pport_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_busy_sync (
        .clk(clk), .rst_n(rst_n), .async_in(busy_in), .sync_out(busy_s)
    );

    // Edge detection on the synchronized acknowledge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ack_prev <= 1'b1;
        else        ack_prev <= ack_s;
    end
    assign ack_fall = ack_prev & ~ack_s;
    assign ack_rise = ~ack_prev & ack_s;

    pport_timer #(.CNT_W(CNT_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val),
        .expired(tmr_exp)
    );

    pport_datareg #(.DATA_W(DATA_W)) u_data (
        .clk(clk), .rst_n(rst_n), .capture(accept), .din(tx_data),
        .dout(pd_out)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Next state, timer loads and completion events
    always_comb begin
        state_nx  = state;
        tmr_load  = 1'b0;
        tmr_val   = '0;
        finish_ok = 1'b0;
        finish_to = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (accept) begin
                    state_nx = ST_SETUP;
                    tmr_load = 1'b1;
                    tmr_val  = SETUP_LD;
                end
            end
            ST_SETUP: begin
                if (tmr_exp) begin
                    state_nx = ST_STROBE;
                    tmr_load = 1'b1;
                    tmr_val  = STB_LD;
                end
            end
            ST_STROBE: begin
                // acknowledge edges are deliberately ignored here
                if (tmr_exp) begin
                    state_nx = ST_WAIT_FALL;
                    tmr_load = 1'b1;
                    tmr_val  = TO_LD;
                end
            end
            ST_WAIT_FALL: begin
                if (ack_fall) begin
                    state_nx = ST_WAIT_RISE;
                end else if (tmr_exp) begin
                    state_nx  = ST_IDLE;
                    finish_to = 1'b1;
                end
            end
            ST_WAIT_RISE: begin
                if (ack_rise) begin
                    state_nx  = ST_IDLE;
                    finish_ok = 1'b1;
                end else if (tmr_exp) begin
                    state_nx  = ST_IDLE;
                    finish_to = 1'b1;
                end
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // Outputs decoded from state
    always_comb begin
        tx_ready = (state == ST_IDLE) && !busy_s;
        strobe_n = (state != ST_STROBE);
        accept   = tx_ready && tx_valid;
    end

    // Sticky result flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done        <= 1'b0;
            timeout_err <= 1'b0;
        end else if (accept) begin
            done        <= 1'b0;
            timeout_err <= 1'b0;
        end else if (finish_ok) begin
            done        <= 1'b1;
        end else if (finish_to) begin
            timeout_err <= 1'b1;
        end
    end
endmodule

// File: rtl/pport_tx_chk.sv
module pport_tx_chk #(
    parameter int DATA_W     = 8,
    parameter int STB_CYCLES = 50
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tx_valid,
    input logic              tx_ready,
    input logic [DATA_W-1:0] pd_out,
    input logic              strobe_n,
    input logic              done,
    input logic              timeout_err
);
    int low_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        low_cnt <= 0;
        else if (strobe_n) low_cnt <= 0;
        else               low_cnt <= low_cnt + 1;
    end

    // R5
    strobe_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(strobe_n) |-> (low_cnt == STB_CYCLES));

    // R3
    data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !strobe_n |-> $stable(pd_out));

    // R2
    busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_ready) |=> !tx_ready);

    // R2
    no_ready_in_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !strobe_n |-> !tx_ready);

    // R6
    no_result_in_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !strobe_n |-> (!done && !timeout_err));

    // R10
    flags_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && timeout_err));

    // R7
    done_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> strobe_n);
endmodule

bind pport_tx pport_tx_chk #(.DATA_W(DATA_W), .STB_CYCLES(STB_CYCLES)) u_chk (
    .clk(clk), .rst_n(rst_n), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .pd_out(pd_out), .strobe_n(strobe_n), .done(done),
    .timeout_err(timeout_err)
);

// File: tb/pport_tx_tb.sv
module pport_tx_tb;
    localparam int DW  = 8;
    localparam int SU  = 3;
    localparam int STB = 20;
    localparam int TO  = 400;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [DW-1:0] tx_data = '0;
    logic tx_valid = 1'b0;
    logic tx_ready, strobe_n, done, timeout_err;
    logic [DW-1:0] pd_out;
    logic ack_n_in = 1'b1;
    logic busy_in = 1'b0;

    int n_checks = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    pport_tx #(
        .DATA_W(DW), .SETUP_CYCLES(SU), .STB_CYCLES(STB),
        .TIMEOUT_CYCLES(TO), .SYNC_STAGES(2)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .tx_data(tx_data), .tx_valid(tx_valid),
        .tx_ready(tx_ready), .pd_out(pd_out), .strobe_n(strobe_n),
        .ack_n_in(ack_n_in), .busy_in(busy_in), .done(done),
        .timeout_err(timeout_err)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic cyc(input int k);
        repeat (k) @(negedge clk);
    endtask

    // offer a byte; returns at the first negedge after the accepting edge
    task automatic offer(input logic [DW-1:0] d);
        int w = 0;
        tx_data  = d;
        tx_valid = 1'b1;
        while (!tx_ready && w < 50) begin
            @(negedge clk);
            w++;
        end
        @(negedge clk);
        tx_valid = 1'b0;
    endtask

    task automatic wait_strobe_low(output int n);
        n = 0;
        while (strobe_n && n < 100) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic count_low(output int n);
        n = 0;
        while (!strobe_n && n < 1000) begin
            @(negedge clk);
            n++;
        end
    endtask

    // acknowledge pulse; returns cycles from release until done
    task automatic ack_pulse(input int low, output int n);
        ack_n_in = 1'b0;
        cyc(low);
        ack_n_in = 1'b1;
        n = 0;
        while (!done && !timeout_err && n < 10) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic t_reset;
        cyc(1);
        chk(strobe_n == 1'b1, "R1 strobe_n", strobe_n, 1);
        chk(done == 1'b0 && timeout_err == 1'b0, "R1 flags", {done, timeout_err}, 0);
        chk(pd_out == '0, "R1 pd_out", pd_out, 0);
        chk(tx_ready == 1'b1, "R1 tx_ready", tx_ready, 1);
    endtask

    task automatic t_basic(input logic [DW-1:0] d);
        int n;
        offer(d);
        chk(pd_out == d, "R3 data on pins", pd_out, d);
        chk(tx_ready == 1'b0, "R2 not ready in transfer", tx_ready, 0);
        chk(done == 1'b0, "R10 done cleared on accept", done, 0);
        wait_strobe_low(n);
        chk(n == SU, "R4 setup length", n, SU);
        count_low(n);
        chk(n == STB, "R5 strobe length", n, STB);
        chk(pd_out == d, "R3 data held after strobe", pd_out, d);
        cyc(4);
        ack_pulse(6, n);
        chk(done == 1'b1 && n == 3, "R7 done latency", n, 3);
        chk(timeout_err == 1'b0, "R10 no error on success", timeout_err, 0);
        chk(tx_ready == 1'b1, "R7 back to idle", tx_ready, 1);
        chk(pd_out == d, "R3 data held until next accept", pd_out, d);
    endtask

    task automatic t_busy;
        logic [DW-1:0] prev;
        int n;
        prev = pd_out;
        busy_in = 1'b1;
        cyc(4);
        chk(tx_ready == 1'b0, "R2 ready low while busy", tx_ready, 0);
        tx_data  = 8'h3C;
        tx_valid = 1'b1;
        cyc(6);
        chk(strobe_n == 1'b1 && pd_out == prev, "R2 no accept while busy", pd_out, prev);
        busy_in = 1'b0;
        n = 0;
        while (!tx_ready && n < 10) begin
            @(negedge clk);
            n++;
        end
        chk(tx_ready == 1'b1, "R2 ready after busy falls", tx_ready, 1);
        @(negedge clk);
        tx_valid = 1'b0;
        chk(pd_out == 8'h3C, "R2 held valid accepted", pd_out, 8'h3C);
        wait_strobe_low(n);
        count_low(n);
        cyc(2);
        ack_pulse(5, n);
        chk(done == 1'b1, "R7 done after busy wait", done, 1);
    endtask

    task automatic t_early_ack;
        int n;
        offer(8'hA5);
        wait_strobe_low(n);
        cyc(2);
        ack_n_in = 1'b0;
        cyc(3);
        ack_n_in = 1'b1;
        count_low(n);
        cyc(8);
        chk(done == 1'b0 && tx_ready == 1'b0, "R6 early ack ignored", done, 0);
        ack_pulse(5, n);
        chk(done == 1'b1 && n == 3, "R7 later ack completes", n, 3);
    endtask

    task automatic t_straddle;
        int n;
        offer(8'h5A);
        wait_strobe_low(n);
        cyc(5);
        ack_n_in = 1'b0;
        count_low(n);
        cyc(5);
        ack_n_in = 1'b1;
        cyc(10);
        chk(done == 1'b0, "R8 straddling ack ignored", done, 0);
        n = 15;
        while (!timeout_err && n < TO + 10) begin
            @(negedge clk);
            n++;
        end
        chk(timeout_err == 1'b1 && done == 1'b0, "R8 ends in timeout", n, TO);
    endtask

    task automatic t_timeout;
        int n;
        offer(8'hC3);
        chk(timeout_err == 1'b0, "R10 error cleared on accept", timeout_err, 0);
        wait_strobe_low(n);
        count_low(n);
        n = 0;
        while (!timeout_err && n < TO + 10) begin
            @(negedge clk);
            n++;
        end
        chk(n == TO, "R9 timeout cycle", n, TO);
        chk(done == 1'b0 && tx_ready == 1'b1, "R9 idle after timeout", tx_ready, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_basic(8'h41);
        t_basic(8'hFF);
        t_busy();
        t_early_ack();
        t_straddle();
        t_timeout();
        t_basic(8'h00);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule